// File: doc/BRIEF.md
# Segmented Shiftable Search-Key Register

This block holds the 64-bit search key that a content-addressable array compares against all of its valid entries at once. Software-side logic loads and reads the key 16 bits at a time through a narrow data port. An internal segment pointer chooses which quarter of the key is accessed. After every access the pointer moves on by one, and it wraps back to a programmable start value once it reaches a programmable end value. A burst of four writes therefore loads the whole key with no extra addressing.

The key can also be rotated by one bit to the left or to the right. The rotation is confined to the CAM field of the word. That field is the top `cam_width` bits of the key, counted down from bit 63. The bits below it belong to the associated-data part of each entry and never move. The whole key is presented continuously on `key_out` to drive the search lines of the array.

Top module: `cmpkey_reg`

## Requirements
- R1: During and after reset, `key_out` is all zeros and `seg_ptr` equals `seg_start`.
- R2: When `wr_en` is high at a clock edge, segment `seg_ptr` is replaced by `wr_data`. Segment k occupies key bits [16k+15:16k]. The other three segments keep their value.
- R3: `rd_data` always shows segment `seg_ptr` of the current key.
- R4: Each cycle with `wr_en` or `rd_en` high advances `seg_ptr` by exactly one, modulo 4. With both strobes high it still advances by one. With neither strobe high it holds.
- R5: An access made while `seg_ptr` equals `seg_end` loads `seg_ptr` with `seg_start` instead of incrementing it.
- R6: With `shl` high and `shr` low, and no write, the CAM field is rotated toward bit 63 by one position. Old bit 63 moves to the lowest CAM bit, which is bit 64-`cam_width`.
- R7: With `shr` high and `shl` low, and no write, the CAM field is rotated toward bit 0 by one position. The old lowest CAM bit moves to bit 63.
- R8: A shift never changes key bits below the CAM field.
- R9: A write in the same cycle as a shift strobe takes effect. The shift is dropped.
- R10: `shl` and `shr` high together cause no change to the key.
- R11: With `cam_width` = 0, shifts leave the key unchanged. Any `cam_width` of 64 or more rotates the full 64-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_start | input | 2 | First segment of the pointer loop, loaded at reset and on wrap |
| seg_end | input | 2 | Last segment of the pointer loop |
| wr_en | input | 1 | Write `wr_data` into the addressed segment |
| wr_data | input | 16 | Segment write data |
| rd_en | input | 1 | Read strobe; advances the pointer |
| rd_data | output | 16 | Addressed segment of the key |
| shl | input | 1 | Rotate CAM field one bit toward the top |
| shr | input | 1 | Rotate CAM field one bit toward the bottom |
| cam_width | input | 7 | Width of the CAM field from bit 63 down |
| seg_ptr | output | 2 | Current segment pointer |
| key_out | output | 64 | Full search key |

## Verification
The assertions assume that `seg_start` is held steady while reset is active. They also assume that `cam_width` does not change in the cycle of a shift whose effect is being checked, since the low-bit mask is taken from the sampled value. The bench changes the limits only while reset is asserted. It moves `cam_width` only in idle cycles, between groups of shifts. Every strobe combination is driven away from the clock edge, including both shifts together and a write alongside a shift.

// File: rtl/cmpkey_pkg.sv
package cmpkey_pkg;

    typedef enum logic [1:0] {
        ROT_HOLD  = 2'd0,
        ROT_UP    = 2'd1,
        ROT_DOWN  = 2'd2
    } rot_op_e;

    // Decode the strobes: a write wins, opposing strobes cancel.
    function automatic rot_op_e decode_rot(input logic wr, input logic up, input logic down);
        rot_op_e op;
        op = ROT_HOLD;
        if (!wr) begin
            if (up && !down)      op = ROT_UP;
            else if (down && !up) op = ROT_DOWN;
        end
        return op;
    endfunction

endpackage

// File: rtl/cmpkey_segptr.sv
module cmpkey_segptr #(
    parameter int unsigned NSEG  = 4,
    parameter int unsigned PTR_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] lim_lo,
    input  logic [PTR_W-1:0] lim_hi,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NSEG - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.ptr == lim_hi)    st_d.ptr = lim_lo;
            else if (st_q.ptr == LAST) st_d.ptr = '0;
            else                       st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ptr <= lim_lo;
        else        st_q     <= st_d;
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/cmpkey_rotator.sv
module cmpkey_rotator
    import cmpkey_pkg::*;
#(
    parameter int unsigned KEY_W  = 64,
    parameter int unsigned PART_W = $clog2(KEY_W + 1)
) (
    input  logic [KEY_W-1:0]  key_i,
    input  logic [PART_W-1:0] field_w,
    input  rot_op_e           op,
    output logic [KEY_W-1:0]  key_o
);
    localparam logic [PART_W-1:0] FULL = PART_W'(KEY_W);

    logic [PART_W-1:0] w_clamped;
    logic [PART_W-1:0] low_edge;
    logic              low_bit;
    logic [KEY_W-1:0]  in_field;
    logic [KEY_W-1:0]  up_v;
    logic [KEY_W-1:0]  down_v;

    always_comb begin
        w_clamped = (field_w > FULL) ? FULL : field_w;
        low_edge  = FULL - w_clamped;
    end

    // Lowest bit of the CAM field, selected by the partition edge.
    always_comb begin
        low_bit = 1'b0;
        for (int j = 0; j < KEY_W; j++) begin
            if (PART_W'(j) == low_edge) low_bit = key_i[j];
        end
    end

    for (genvar i = 0; i < KEY_W; i++) begin : g_bit
        assign in_field[i] = (PART_W'(i) >= low_edge);

        if (i == 0) begin : g_bottom
            assign up_v[i] = key_i[KEY_W-1];
        end else begin : g_mid_up
            assign up_v[i] = (PART_W'(i) == low_edge) ? key_i[KEY_W-1] : key_i[i-1];
        end

        if (i == KEY_W - 1) begin : g_top
            assign down_v[i] = low_bit;
        end else begin : g_mid_down
            assign down_v[i] = key_i[i+1];
        end
    end

    always_comb begin
        key_o = key_i;
        for (int k = 0; k < KEY_W; k++) begin
            if (in_field[k]) begin
                case (op)
                    ROT_UP:   key_o[k] = up_v[k];
                    ROT_DOWN: key_o[k] = down_v[k];
                    default:  key_o[k] = key_i[k];
                endcase
            end
        end
    end

endmodule

// File: rtl/cmpkey_reg.sv
module cmpkey_reg
    import cmpkey_pkg::*;
#(
    parameter int unsigned KEY_W  = 64,
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned NSEG   = KEY_W / SEG_W,
    parameter int unsigned PTR_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
    parameter int unsigned PART_W = $clog2(KEY_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  seg_start,
    input  logic [PTR_W-1:0]  seg_end,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [SEG_W-1:0]  rd_data,
    input  logic              shl,
    input  logic              shr,
    input  logic [PART_W-1:0] cam_width,
    output logic [PTR_W-1:0]  seg_ptr,
    output logic [KEY_W-1:0]  key_out
);
    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] key;
    } key_state_t;

    key_state_t        st_d, st_q;
    rot_op_e           rot_op;
    logic [KEY_W-1:0]  rotated;
    logic [PTR_W-1:0]  ptr;

    cmpkey_segptr #(
        .NSEG  (NSEG),
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lim_lo (seg_start),
        .lim_hi (seg_end),
        .step   (wr_en | rd_en),
        .ptr    (ptr)
    );

    assign rot_op = decode_rot(wr_en, shl, shr);

    cmpkey_rotator #(
        .KEY_W  (KEY_W),
        .PART_W (PART_W)
    ) u_rot (
        .key_i   (st_q.key),
        .field_w (cam_width),
        .op      (rot_op),
        .key_o   (rotated)
    );

    always_comb begin
        st_d.key = rotated;
        if (wr_en) begin
            st_d.key      = st_q.key;
            st_d.key[ptr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.key[ptr];
    assign seg_ptr = ptr;
    assign key_out = st_q.key;

endmodule

// File: rtl/cmpkey_chk.sv
module cmpkey_chk #(
    parameter int unsigned KEY_W  = 64,
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned NSEG   = KEY_W / SEG_W,
    parameter int unsigned PTR_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
    parameter int unsigned PART_W = $clog2(KEY_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  seg_start,
    input logic [PTR_W-1:0]  seg_end,
    input logic              wr_en,
    input logic [SEG_W-1:0]  wr_data,
    input logic              rd_en,
    input logic              shl,
    input logic              shr,
    input logic [PART_W-1:0] cam_width,
    input logic [PTR_W-1:0]  seg_ptr,
    input logic [KEY_W-1:0]  key_out
);
    logic seen;

    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    function automatic logic [SEG_W-1:0] pick(input logic [KEY_W-1:0] k, input logic [PTR_W-1:0] p);
        logic [NSEG-1:0][SEG_W-1:0] v;
        v = k;
        return v[p];
    endfunction

    function automatic logic [KEY_W-1:0] below(input logic [PART_W-1:0] w);
        logic [KEY_W-1:0] m;
        int unsigned      edge_i;
        edge_i = (int'(w) >= KEY_W) ? 0 : KEY_W - int'(w);
        for (int i = 0; i < KEY_W; i++) m[i] = (i < edge_i);
        return m;
    endfunction

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (key_out == '0) && (seg_ptr == seg_start));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(wr_en) |-> pick(key_out, $past(seg_ptr)) == $past(wr_data));

    a_r4_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!wr_en && !rd_en) |-> $stable(seg_ptr));

    a_r5_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past((wr_en || rd_en) && (seg_ptr == seg_end)) |-> seg_ptr == $past(seg_start));

    a_r6_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!wr_en && (shl || shr)) |-> $countones(key_out) == $countones($past(key_out)));

    a_r8_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!wr_en && (shl || shr)) |->
            (key_out & below($past(cam_width))) == ($past(key_out) & below($past(cam_width))));

    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(!wr_en && shl && shr) |-> $stable(key_out));

endmodule

bind cmpkey_reg cmpkey_chk #(
    .KEY_W  (KEY_W),
    .SEG_W  (SEG_W),
    .NSEG   (NSEG),
    .PTR_W  (PTR_W),
    .PART_W (PART_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_start (seg_start),
    .seg_end   (seg_end),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .shl       (shl),
    .shr       (shr),
    .cam_width (cam_width),
    .seg_ptr   (seg_ptr),
    .key_out   (key_out)
);

// File: tb/sim_cmpkey_reg.sv
`timescale 1ns/1ps
module sim_cmpkey_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  seg_start, seg_end, seg_ptr;
    logic        wr_en, rd_en, shl, shr;
    logic [15:0] wr_data, rd_data;
    logic [6:0]  cam_width;
    logic [63:0] key_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [63:0] m_key;
    logic [1:0]  m_ptr;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    cmpkey_reg u0 (
        .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_end(seg_end),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .shl(shl), .shr(shr), .cam_width(cam_width), .seg_ptr(seg_ptr), .key_out(key_out)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:16];
    endfunction

    function automatic logic [63:0] model_rot(input logic [63:0] k, input int w_in, input bit up);
        int w;
        logic [63:0] mask, f, nf;
        w = (w_in > 64) ? 64 : w_in;
        if (w == 0) return k;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        f    = k >> (64 - w);
        if (up) nf = ((f << 1) | (f >> (w - 1))) & mask;
        else    nf = ((f >> 1) | ((f & 64'd1) << (w - 1))) & mask;
        return (k & ~(mask << (64 - w))) | (nf << (64 - w));
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One cycle of stimulus with the model updated from the requirements.
    task automatic cyc(input bit w, input bit r, input logic [15:0] d, input bit l, input bit rr);
        wr_en = w; rd_en = r; wr_data = d; shl = l; shr = rr;
        if (w)            m_key[m_ptr*16 +: 16] = d;
        else if (l && !rr) m_key = model_rot(m_key, int'(cam_width), 1'b1);
        else if (rr && !l) m_key = model_rot(m_key, int'(cam_width), 1'b0);
        if (w || r) m_ptr = (m_ptr == seg_end) ? seg_start : m_ptr + 2'd1;
        tick();
        wr_en = 0; rd_en = 0; shl = 0; shr = 0;
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [1:0] e);
        rst_n = 0; seg_start = s; seg_end = e;
        tick(); tick();
        check(key_out == 64'd0, "R1 key", key_out, 64'd0);
        check(seg_ptr == s, "R1 ptr", {62'd0, seg_ptr}, {62'd0, s});
        rst_n = 1;
        m_key = '0; m_ptr = s;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; shl = 0; shr = 0; wr_data = 0;
        cam_width = 7'd64; seg_start = 2; seg_end = 1;
        #2;
        do_reset(2'd2, 2'd1);

        // Pointer sweep over every start/end pair.
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                do_reset(2'(s), 2'(e));
                for (int n = 0; n < 7; n++) begin
                    logic [15:0] d;
                    d = next_rand();
                    check(rd_data == m_key[m_ptr*16 +: 16], "R3 rd_data", {48'd0, rd_data}, {48'd0, m_key[m_ptr*16 +: 16]});
                    cyc(n[0], !n[0] || (n == 5), d, 1'b0, 1'b0);
                    check(seg_ptr == m_ptr, "R4/R5 pointer step", {62'd0, seg_ptr}, {62'd0, m_ptr});
                    check(key_out == m_key, "R2 segment write", key_out, m_key);
                end
                cyc(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0);
                check(seg_ptr == m_ptr, "R4 idle hold", {62'd0, seg_ptr}, {62'd0, m_ptr});
            end
        end

        // Shift sweep over every partition width, including out-of-range ones.
        do_reset(2'd0, 2'd3);
        for (int w = 0; w <= 66; w++) begin
            string tag;
            cam_width = 7'(w);
            tag = (w == 0 || w >= 64) ? "R11" : "R6/R8";
            for (int g = 0; g < 4; g++) cyc(1'b1, 1'b0, next_rand(), 1'b0, 1'b0);
            check(key_out == m_key, "R2 full load", key_out, m_key);
            for (int n = 0; n < 3; n++) begin
                cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
                check(key_out == m_key, {tag, " left rotate"}, key_out, m_key);
            end
            tag = (w == 0 || w >= 64) ? "R11" : "R7/R8";
            for (int n = 0; n < 4; n++) begin
                cyc(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
                check(key_out == m_key, {tag, " right rotate"}, key_out, m_key);
            end
            cyc(1'b0, 1'b0, 16'h0, 1'b1, 1'b1);
            check(key_out == m_key, "R10 both strobes", key_out, m_key);
            cyc(1'b1, 1'b0, next_rand(), w[0], !w[0]);
            check(key_out == m_key, "R9 write beats shift", key_out, m_key);
            check(seg_ptr == m_ptr, "R9 pointer", {62'd0, seg_ptr}, {62'd0, m_ptr});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule